// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a real-time-clock peripheral that sits behind a simple memory-mapped register bus in a 4 KB address window. It keeps a free-running seconds counter that advances on cycles where an external one-second tick enable is high. Tick generation from an oscillator happens outside the block. Software can load a new time and program an alarm value. When the counter arrives at the alarm value, a raw interrupt flag is set. That flag drives a level interrupt output through a one-bit mask. The flag stays set until software writes the clear register.

Bus writes take effect at the rising clock edge on which `wr_en_i` is high. Read data comes straight from the addressed state and needs no wait cycle. All offsets are byte addresses, and the block decodes them on word boundaries (address bits [1:0] are ignored). Eight identification bytes occupy the top 32 bytes of the window.

Top module: `sec_rtc`

## Requirements
- R1: The counter (read at 0x00) increases by exactly one after each clock edge at which `tick_i` is high. It holds its value otherwise, and after 0xFFFFFFFF it wraps to 0.
- R2: A write to 0x08 makes the counter take the written value at that edge, even when `tick_i` is high in the same cycle. A read of 0x08 returns the last value written there.
- R3: The raw flag (bit 0 at 0x14) is set on the edge at which the counter reaches the match value held at 0x04. The compare uses 32-bit wraparound, so a match value below the count fires only after the counter wraps.
- R4: A write to 0x04 or 0x08 that makes the count equal the match value sets the raw flag at that same edge.
- R5: A write to 0x10 stores only data bit 0 as the mask. `irq_o` and the masked status (bit 0 at 0x18) both equal the raw flag ANDed with the mask.
- R6: Any write to 0x1C clears the raw flag, whatever the data. If a new match occurs at the same edge, the flag is set instead.
- R7: A read of 0x0C always returns 1, and writes to 0x0C change nothing.
- R8: Reads of 0xFE0, 0xFE4, …, 0xFFC return 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, in bits [7:0], with all upper bits zero.
- R9: Reads of 0x1C and of undefined offsets return 0. Writes to 0x00, 0x14, 0x18 and to undefined offsets have no effect.
- R10: After reset, the counter, match, load value, mask and raw flag all read 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick enable |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | AW (12) | Byte address inside the window |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt: raw flag AND mask |

## Verification
The bench builds the block with its default parameters: 32-bit data and a 12-bit address. With these values the identification bytes sit at the top of a real 4 KB window, and the full 32-bit wraparound can be checked. The counter is loaded just below 0xFFFFFFFF, so the wrap and a match that fires only after it both happen within a few ticks. The same-edge cases are driven on purpose: load together with tick, and clear together with a match.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // word indices (byte offset >> 2)
  localparam logic [9:0] W_COUNT  = 10'h000;
  localparam logic [9:0] W_MATCH  = 10'h001;
  localparam logic [9:0] W_LOAD   = 10'h002;
  localparam logic [9:0] W_CTRL   = 10'h003;
  localparam logic [9:0] W_MASK   = 10'h004;
  localparam logic [9:0] W_RAW    = 10'h005;
  localparam logic [9:0] W_MSTAT  = 10'h006;
  localparam logic [9:0] W_CLEAR  = 10'h007;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h31;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cnt_next_o,
  output logic          cnt_upd_o,
  output logic [DW-1:0] load_o
);
  logic [DW-1:0] cnt_q, load_q;

  // load beats tick
  always_comb begin
    cnt_next_o = cnt_q;
    if (load_wr_i)   cnt_next_o = wdata_i;
    else if (tick_i) cnt_next_o = cnt_q + DW'(1);
  end
  assign cnt_upd_o = load_wr_i | tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else begin
      cnt_q <= cnt_next_o;
      if (load_wr_i) load_q <= wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;

  a_r1_tick_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_wr_i) |=> cnt_q == $past(cnt_q) + DW'(1));
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_wr_i) |=> $stable(cnt_q));
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr_i |=> (cnt_q == $past(wdata_i)) && (load_q == $past(wdata_i)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          match_wr_i,
  input  logic          mask_wr_i,
  input  logic          clr_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_next_i,
  input  logic          cnt_upd_i,
  output logic [DW-1:0] match_o,
  output logic          mask_o,
  output logic          raw_o,
  output logic          irq_o
);
  logic [DW-1:0] match_q, match_d;
  logic          mask_q, raw_q, evt;

  assign match_d = match_wr_i ? wdata_i : match_q;
  // fire only when count or match changes into equality
  assign evt = (cnt_upd_i | match_wr_i) && (cnt_next_i == match_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      match_q <= match_d;
      if (mask_wr_i) mask_q <= wdata_i[0];
      if (evt)           raw_q <= 1'b1;
      else if (clr_wr_i) raw_q <= 1'b0;
    end
  end

  assign match_o = match_q;
  assign mask_o  = mask_q;
  assign raw_o   = raw_q;
  assign irq_o   = raw_q & mask_q;

  a_r3_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> raw_q);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !evt) |=> !raw_q);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q && !clr_wr_i) |=> raw_q);
  a_r5_mask_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> mask_q == $past(wdata_i[0]));
endmodule

// File: rtl/rtc_regdec.sv
module rtc_regdec
  import rtc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] match_i,
  input  logic [DW-1:0] load_i,
  input  logic          mask_i,
  input  logic          raw_i,
  output logic          load_wr_o,
  output logic          match_wr_o,
  output logic          mask_wr_o,
  output logic          clr_wr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int WW = AW - 2;
  logic [WW-1:0] widx;
  logic          in_id;

  assign widx  = addr_i[AW-1:2];
  assign in_id = &widx[WW-1:3];

  assign load_wr_o  = wr_en_i && (widx == WW'(W_LOAD));
  assign match_wr_o = wr_en_i && (widx == WW'(W_MATCH));
  assign mask_wr_o  = wr_en_i && (widx == WW'(W_MASK));
  assign clr_wr_o   = wr_en_i && (widx == WW'(W_CLEAR));

  always_comb begin
    rdata_o = '0;
    if (in_id) rdata_o = DW'(id_byte(widx[2:0]));
    else begin
      case (widx)
        WW'(W_COUNT): rdata_o = cnt_i;
        WW'(W_MATCH): rdata_o = match_i;
        WW'(W_LOAD):  rdata_o = load_i;
        WW'(W_CTRL):  rdata_o = DW'(1);
        WW'(W_MASK):  rdata_o = DW'(mask_i);
        WW'(W_RAW):   rdata_o = DW'(raw_i);
        WW'(W_MSTAT): rdata_o = DW'(raw_i & mask_i);
        default:      rdata_o = '0;
      endcase
    end
  end

  // R9: at most one strobe per write
  always_comb a_r9_one_strobe: assert ($onehot0({load_wr_o, match_wr_o, mask_wr_o, clr_wr_o}));
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [DW-1:0] cnt, cnt_next, load_val, match_val;
  logic          cnt_upd, load_wr, match_wr, mask_wr, clr_wr, mask, raw;

  rtc_regdec #(.AW(AW), .DW(DW)) u_dec (
    .wr_en_i(wr_en_i), .addr_i(addr_i), .cnt_i(cnt), .match_i(match_val),
    .load_i(load_val), .mask_i(mask), .raw_i(raw), .load_wr_o(load_wr),
    .match_wr_o(match_wr), .mask_wr_o(mask_wr), .clr_wr_o(clr_wr), .rdata_o(rdata_o)
  );

  rtc_counter #(.DW(DW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .load_wr_i(load_wr),
    .wdata_i(wdata_i), .cnt_o(cnt), .cnt_next_o(cnt_next), .cnt_upd_o(cnt_upd),
    .load_o(load_val)
  );

  rtc_alarm #(.DW(DW)) u_alm (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_wr_i(match_wr), .mask_wr_i(mask_wr),
    .clr_wr_i(clr_wr), .wdata_i(wdata_i), .cnt_next_i(cnt_next), .cnt_upd_i(cnt_upd),
    .match_o(match_val), .mask_o(mask), .raw_o(raw), .irq_o(irq_o)
  );

  a_r4_match_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((load_wr || match_wr) && (cnt_next == (match_wr ? wdata_i : match_val))) |=> raw);
  a_r7_no_ctrl_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[AW-1:2] == (AW-2)'(3) && !tick_i) |=> $stable(cnt) && $stable(match_val));
endmodule

// File: tb/sec_rtc_tb.sv
`timescale 1ns/1ps
module sec_rtc_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sec_rtc u_dut (.clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // {write, addr, data-or-expected}
  localparam int NV = 23;
  localparam logic [44:0] VEC [0:NV-1] = '{
    {1'b1, 12'h004, 32'd5},      {1'b0, 12'h004, 32'd5},
    {1'b1, 12'h008, 32'h100},    {1'b0, 12'h008, 32'h100},
    {1'b0, 12'h000, 32'h100},    {1'b0, 12'h00C, 32'd1},
    {1'b1, 12'h00C, 32'd0},      {1'b0, 12'h00C, 32'd1},
    {1'b1, 12'h010, 32'd3},      {1'b0, 12'h010, 32'd1},
    {1'b0, 12'h01C, 32'd0},      {1'b0, 12'h020, 32'd0},
    {1'b0, 12'hFE0, 32'h31},     {1'b0, 12'hFE4, 32'h10},
    {1'b0, 12'hFE8, 32'h14},     {1'b0, 12'hFEC, 32'h00},
    {1'b0, 12'hFF0, 32'h0D},     {1'b0, 12'hFF4, 32'hF0},
    {1'b0, 12'hFF8, 32'h05},     {1'b0, 12'hFFC, 32'hB1},
    {1'b0, 12'h014, 32'd0},      {1'b0, 12'h018, 32'd0},
    {1'b0, 12'hF00, 32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic t = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10 reset state
    rd(12'h000, v); chk("R10 count", v, 0);
    rd(12'h004, v); chk("R10 match", v, 0);
    rd(12'h008, v); chk("R10 load", v, 0);
    rd(12'h010, v); chk("R10 mask", v, 0);
    rd(12'h014, v); chk("R10 raw", v, 0);
    chk("R10 irq", 32'(irq), 0);

    // table walk: R2 R3 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][43:32], v);
        chk($sformatf("R2/R5/R7/R8/R9 vec%0d", i), v, VEC[i][31:0]);
      end
    end

    // R1 tick and hold
    ticks(3);
    rd(12'h000, v); chk("R1 three ticks", v, 32'h103);
    repeat (2) @(negedge clk);
    rd(12'h000, v); chk("R1 hold", v, 32'h103);

    // R2 load beats tick
    wr(12'h008, 32'h200, 1'b1);
    rd(12'h000, v); chk("R2 load over tick", v, 32'h200);
    rd(12'h014, v); chk("R2 no false raw", v, 0);

    // R4 match write equal to count fires now; R5 mask=1
    wr(12'h004, 32'h200);
    rd(12'h014, v); chk("R4 raw on match write", v, 1);
    chk("R5 irq masked on", 32'(irq), 1);
    rd(12'h018, v); chk("R5 masked status", v, 1);

    // R6 clear with zero data
    wr(12'h01C, 32'h0);
    rd(12'h014, v); chk("R6 clear any data", v, 0);
    chk("R6 irq low", 32'(irq), 0);

    // R5 mask off, then R3 match by ticking
    wr(12'h010, 32'hFFFF_FFFE);
    wr(12'h004, 32'h202);
    ticks(2);
    rd(12'h014, v); chk("R3 raw on tick match", v, 1);
    chk("R5 irq gated", 32'(irq), 0);
    rd(12'h018, v); chk("R5 masked status gated", v, 0);
    wr(12'h010, 32'h1);
    chk("R5 irq after unmask", 32'(irq), 1);
    wr(12'h01C, 32'h5A);

    // R1/R3 wraparound
    wr(12'h004, 32'd1);
    wr(12'h008, 32'hFFFF_FFFE);
    rd(12'h014, v); chk("R3 no early fire", v, 0);
    ticks(2);
    rd(12'h000, v); chk("R1 wrap to zero", v, 0);
    rd(12'h014, v); chk("R3 not yet", v, 0);
    ticks(1);
    rd(12'h014, v); chk("R3 fires after wrap", v, 1);
    wr(12'h01C, 32'h0);

    // R4 load write equal to match
    wr(12'h008, 32'd1);
    rd(12'h014, v); chk("R4 raw on load write", v, 1);
    wr(12'h01C, 32'h0);

    // R6 set wins over clear in same edge
    wr(12'h004, 32'd10);
    wr(12'h008, 32'd9);
    wr(12'h01C, 32'h0, 1'b1);
    rd(12'h014, v); chk("R6 set beats clear", v, 1);
    wr(12'h01C, 32'h0);

    // R9 writes to read-only / undefined, R7 control write
    wr(12'h000, 32'h55);
    wr(12'h014, 32'h1);
    wr(12'h018, 32'h1);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h00C, 32'h0);
    rd(12'h000, v); chk("R9 count untouched", v, 32'd10);
    rd(12'h014, v); chk("R9 raw untouched", v, 0);
    rd(12'h004, v); chk("R9 match untouched", v, 32'd10);
    rd(12'h008, v); chk("R9 load untouched", v, 32'd9);
    rd(12'h020, v); chk("R9 undefined reads zero", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule